// File: doc/BRIEF.md
# Memory Micro-op Port Dispatcher

Each cycle this block receives a small group of ready memory micro-ops and places them on the execution ports that can run them. A micro-op is a load, a store-address or a store-data operation. It carries a tag, a flag that marks an address formed with an index register, and a flag that marks a 256-bit operation. The four ports are not alike. Two general address ports each take one load or one store-address per cycle. A dedicated address port takes only store-addresses without an index register. A single store-data port takes one store-data micro-op per cycle.

Inputs use valid/ready. `in_ready[i]` is high in the same cycle as `in_valid[i]` when slot i has been placed. `in_ready` may depend on `in_valid` and on the slot contents in that cycle, and it never rises without `in_valid`. A slot that sees `in_valid` high and `in_ready` low has not been consumed. The producer keeps it and offers it again in a later cycle. The issue outputs are plain strobes. The execution ports always take what is issued to them.

A 256-bit load or store-data operation runs as two 128-bit halves and holds its data path for two cycles. The issue strobe marks the first half. In the second cycle a general port still accepts a store-address, but not a load. The store-data port accepts nothing in that cycle.

Top module: `mem_port_dispatch`

## Requirements
- R1: A load goes only to a general port (port 0 or 1). The lowest-numbered general port that is free for loads is used, and no port receives more than one micro-op per cycle.
- R2: A store-address without an index register goes to the dedicated port 2 when that port is free, and otherwise to a general port. Two loads, one such store-address and one store-data, all offered together, are all accepted in one cycle.
- R3: A store-address with an index register never goes to port 2. It uses a general port or is rejected.
- R4: Store-data micro-ops go only to port 3, at most one per cycle.
- R5: Slots are ranked by age, with slot 0 the oldest. Each slot is placed in age order, and an older slot claims ports before any younger one.
- R6: Once a slot of some kind is rejected in a cycle, every younger slot of the same kind is also rejected in that cycle, even if a port could take it.
- R7: Issuing a 256-bit load (kind 00 with the wide flag set) on a general port stops that port from taking a load in the next cycle, while it still takes a store-address. A store-address headed for a general port prefers a port that is in such a second half.
- R8: Issuing a 256-bit store-data (kind 10 with the wide flag set) stops port 3 from issuing anything in the next cycle.
- R9: `in_ready[i]` is high only when `in_valid[i]` is high and the slot was placed. The number of accepted slots equals the number of asserted `iss_valid` bits. With no valid input, no port issues.
- R10: Kind encoding: 00 load, 01 store-address, 10 store-data. A slot of kind 11 is never accepted and has no effect on the placement of other slots.
- R11: After reset no port is in a second half, and all issue and ready outputs are low while no input is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | N_SLOT | Slot holds a micro-op |
| in_kind | input | 2*N_SLOT | Kind per slot (00 load, 01 store-address, 10 store-data, 11 reserved) |
| in_indexed | input | N_SLOT | Address uses an index register |
| in_wide | input | N_SLOT | 256-bit operation (affects loads and store-data) |
| in_tag | input | N_SLOT*TAG_W | Tag per slot |
| in_ready | output | N_SLOT | Slot accepted this cycle |
| iss_valid | output | NGEN+2 | Issue strobe per port (general ports, then port NGEN for simple store-address, then port NGEN+1 for store-data) |
| iss_tag | output | (NGEN+2)*TAG_W | Tag issued on each port, zero when idle |
| iss_wide | output | NGEN+2 | Issued micro-op is a 256-bit load or store-data |
| gen_is_load | output | NGEN | General port issues a load (low means store-address) |

## Verification
Every cycle the assertions check port legality: port 2 only ever receives a store-address without an index register, and port 3 only receives store-data. They also check that the count of accepted slots matches the count of issue strobes, that nothing issues with no input, that a reserved kind is never accepted, that rejection within a kind passes on to all younger slots of that kind, and that a wide first half is never followed by a conflicting issue on the same data path. What they cannot show is that the choice made was the right one. That covers whether the lowest free port was picked, whether a store-address moved to a port that is in a second half, and whether the peak mix was fully accepted. Those are shown by the bench comparing every output, cycle by cycle, against its reference model over directed sequences and a long random run.

// File: rtl/mpd_pkg.sv
`timescale 1ns/1ps
package mpd_pkg;
  typedef enum logic [1:0] {
    K_LOAD = 2'b00,
    K_STA  = 2'b01,
    K_STD  = 2'b10,
    K_RSV  = 2'b11
  } mop_kind_e;

  localparam int KIND_W = 2;

  // Returns the lowest set bit of a request mask as a one-hot value.
  function automatic logic [7:0] lowest_one(input logic [7:0] m);
    logic [7:0] r;
    r = '0;
    for (int b = 7; b >= 0; b--) begin
      if (m[b]) r = 8'(1) << b;
    end
    return r;
  endfunction
endpackage

// File: rtl/mpd_slot_decode.sv
`timescale 1ns/1ps
module mpd_slot_decode
  import mpd_pkg::*;
#(
  parameter int N_SLOT = 4
) (
  input  logic [N_SLOT-1:0]        in_valid,
  input  logic [KIND_W*N_SLOT-1:0] in_kind,
  output logic [N_SLOT-1:0]        is_load,
  output logic [N_SLOT-1:0]        is_sta,
  output logic [N_SLOT-1:0]        is_std
);
  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    mop_kind_e k;
    assign k          = mop_kind_e'(in_kind[i*KIND_W +: KIND_W]);
    assign is_load[i] = in_valid[i] && (k == K_LOAD);
    assign is_sta[i]  = in_valid[i] && (k == K_STA);
    assign is_std[i]  = in_valid[i] && (k == K_STD);
  end
endmodule

// File: rtl/mpd_occupancy.sv
`timescale 1ns/1ps
module mpd_occupancy #(
  parameter int NGEN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGEN-1:0] set_gbusy,
  input  logic            set_sdbusy,
  output logic [NGEN-1:0] gbusy_q,
  output logic            sdbusy_q
);
  // A wide operation's second half lasts exactly one cycle.
  for (genvar j = 0; j < NGEN; j++) begin : g_gen
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gbusy_q[j] <= 1'b0;
      else        gbusy_q[j] <= set_gbusy[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdbusy_q <= 1'b0;
    else        sdbusy_q <= set_sdbusy;
  end
endmodule

// File: rtl/mpd_arbiter.sv
`timescale 1ns/1ps
module mpd_arbiter
  import mpd_pkg::*;
#(
  parameter int N_SLOT = 4,
  parameter int NGEN   = 2
) (
  input  logic [N_SLOT-1:0]                is_load,
  input  logic [N_SLOT-1:0]                is_sta,
  input  logic [N_SLOT-1:0]                is_std,
  input  logic [N_SLOT-1:0]                indexed,
  input  logic [NGEN-1:0]                  gbusy,
  input  logic                             sdbusy,
  output logic [N_SLOT-1:0][NGEN+1:0]      gnt,
  output logic [N_SLOT-1:0]                accept
);
  localparam int NPORT   = NGEN + 2;
  localparam int PORT_SA = NGEN;
  localparam int PORT_SD = NGEN + 1;

  logic [NGEN-1:0] gfree;
  logic            sa_free;
  logic            sd_free;
  logic            blk_ld, blk_sa, blk_sd;
  logic [NGEN-1:0] cand, pref, pick;
  logic [7:0]      pick8;

  always_comb begin
    gfree   = '1;
    sa_free = 1'b1;
    sd_free = !sdbusy;
    blk_ld  = 1'b0;
    blk_sa  = 1'b0;
    blk_sd  = 1'b0;
    gnt     = '0;
    accept  = '0;
    cand    = '0;
    pref    = '0;
    pick    = '0;
    pick8   = '0;
    for (int i = 0; i < N_SLOT; i++) begin
      if (is_load[i] && !blk_ld) begin
        cand  = gfree & ~gbusy;
        pick8 = lowest_one(8'(cand));
        pick  = pick8[NGEN-1:0];
        if (|pick) begin
          gnt[i][NGEN-1:0] = pick;
          gfree            = gfree & ~pick;
          accept[i]        = 1'b1;
        end else begin
          blk_ld = 1'b1;
        end
      end else if (is_sta[i] && !blk_sa) begin
        if (!indexed[i] && sa_free) begin
          gnt[i][PORT_SA] = 1'b1;
          sa_free         = 1'b0;
          accept[i]       = 1'b1;
        end else begin
          cand  = gfree;
          pref  = gfree & gbusy;
          pick8 = (|pref) ? lowest_one(8'(pref)) : lowest_one(8'(cand));
          pick  = pick8[NGEN-1:0];
          if (|pick) begin
            gnt[i][NGEN-1:0] = pick;
            gfree            = gfree & ~pick;
            accept[i]        = 1'b1;
          end else begin
            blk_sa = 1'b1;
          end
        end
      end else if (is_std[i] && !blk_sd) begin
        if (sd_free) begin
          gnt[i][PORT_SD] = 1'b1;
          sd_free         = 1'b0;
          accept[i]       = 1'b1;
        end else begin
          blk_sd = 1'b1;
        end
      end
    end
  end

  logic unused_np;
  assign unused_np = (NPORT == 0);
endmodule

// File: rtl/mpd_port_mux.sv
`timescale 1ns/1ps
module mpd_port_mux #(
  parameter int N_SLOT = 4,
  parameter int NGEN   = 2,
  parameter int TAG_W  = 6
) (
  input  logic [N_SLOT-1:0][NGEN+1:0]  gnt,
  input  logic [N_SLOT*TAG_W-1:0]      in_tag,
  input  logic [N_SLOT-1:0]            in_wide,
  input  logic [N_SLOT-1:0]            is_load,
  input  logic [N_SLOT-1:0]            is_std,
  output logic [NGEN+1:0]              iss_valid,
  output logic [(NGEN+2)*TAG_W-1:0]    iss_tag,
  output logic [NGEN+1:0]              iss_wide,
  output logic [NGEN-1:0]              gen_is_load,
  output logic [NGEN-1:0]              set_gbusy,
  output logic                         set_sdbusy
);
  localparam int NPORT   = NGEN + 2;
  localparam int PORT_SD = NGEN + 1;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_comb begin
      iss_valid[p]            = 1'b0;
      iss_wide[p]             = 1'b0;
      iss_tag[p*TAG_W +: TAG_W] = '0;
      for (int i = 0; i < N_SLOT; i++) begin
        if (gnt[i][p]) begin
          iss_valid[p]              = 1'b1;
          iss_wide[p]               = in_wide[i] && (is_load[i] || is_std[i]);
          iss_tag[p*TAG_W +: TAG_W] = in_tag[i*TAG_W +: TAG_W];
        end
      end
    end
  end

  for (genvar j = 0; j < NGEN; j++) begin : g_gen
    always_comb begin
      gen_is_load[j] = 1'b0;
      for (int i = 0; i < N_SLOT; i++) begin
        if (gnt[i][j] && is_load[i]) gen_is_load[j] = 1'b1;
      end
    end
    assign set_gbusy[j] = iss_valid[j] && gen_is_load[j] && iss_wide[j];
  end

  assign set_sdbusy = iss_valid[PORT_SD] && iss_wide[PORT_SD];
endmodule

// File: rtl/mem_port_dispatch.sv
`timescale 1ns/1ps
module mem_port_dispatch #(
  parameter int N_SLOT = 4,
  parameter int NGEN   = 2,
  parameter int TAG_W  = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_SLOT-1:0]           in_valid,
  input  logic [2*N_SLOT-1:0]         in_kind,
  input  logic [N_SLOT-1:0]           in_indexed,
  input  logic [N_SLOT-1:0]           in_wide,
  input  logic [N_SLOT*TAG_W-1:0]     in_tag,
  output logic [N_SLOT-1:0]           in_ready,
  output logic [NGEN+1:0]             iss_valid,
  output logic [(NGEN+2)*TAG_W-1:0]   iss_tag,
  output logic [NGEN+1:0]             iss_wide,
  output logic [NGEN-1:0]             gen_is_load
);
  logic [N_SLOT-1:0]           is_load, is_sta, is_std;
  logic [N_SLOT-1:0][NGEN+1:0] gnt;
  logic [NGEN-1:0]             gbusy_q, set_gbusy;
  logic                        sdbusy_q, set_sdbusy;

  mpd_slot_decode #(.N_SLOT(N_SLOT)) u_dec (
    .in_valid (in_valid),
    .in_kind  (in_kind),
    .is_load  (is_load),
    .is_sta   (is_sta),
    .is_std   (is_std)
  );

  mpd_arbiter #(.N_SLOT(N_SLOT), .NGEN(NGEN)) u_arb (
    .is_load (is_load),
    .is_sta  (is_sta),
    .is_std  (is_std),
    .indexed (in_indexed),
    .gbusy   (gbusy_q),
    .sdbusy  (sdbusy_q),
    .gnt     (gnt),
    .accept  (in_ready)
  );

  mpd_port_mux #(.N_SLOT(N_SLOT), .NGEN(NGEN), .TAG_W(TAG_W)) u_mux (
    .gnt         (gnt),
    .in_tag      (in_tag),
    .in_wide     (in_wide),
    .is_load     (is_load),
    .is_std      (is_std),
    .iss_valid   (iss_valid),
    .iss_tag     (iss_tag),
    .iss_wide    (iss_wide),
    .gen_is_load (gen_is_load),
    .set_gbusy   (set_gbusy),
    .set_sdbusy  (set_sdbusy)
  );

  mpd_occupancy #(.NGEN(NGEN)) u_occ (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_gbusy  (set_gbusy),
    .set_sdbusy (set_sdbusy),
    .gbusy_q    (gbusy_q),
    .sdbusy_q   (sdbusy_q)
  );
endmodule

// File: rtl/mpd_checker.sv
`timescale 1ns/1ps
module mpd_checker #(
  parameter int N_SLOT = 4,
  parameter int NGEN   = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_SLOT-1:0]           in_valid,
  input logic [2*N_SLOT-1:0]         in_kind,
  input logic [N_SLOT-1:0]           in_indexed,
  input logic [N_SLOT-1:0]           in_ready,
  input logic [NGEN+1:0]             iss_valid,
  input logic [NGEN+1:0]             iss_wide,
  input logic [NGEN-1:0]             gen_is_load,
  input logic [N_SLOT-1:0][NGEN+1:0] gnt
);
  localparam int PORT_SA = NGEN;
  localparam int PORT_SD = NGEN + 1;

  p_ready_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);
  p_count_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_ready) == $countones(iss_valid));
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid == '0) |-> (iss_valid == '0));
  p_wide_std_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid[PORT_SD] && iss_wide[PORT_SD]) |=> !iss_valid[PORT_SD]);

  for (genvar j = 0; j < NGEN; j++) begin : g_gen
    p_wide_load_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid[j] && gen_is_load[j] && iss_wide[j]) |=> !(iss_valid[j] && gen_is_load[j]));
  end

  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    p_sa_simple_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i][PORT_SA] |-> (in_kind[2*i +: 2] == 2'b01) && !in_indexed[i]);
    p_sd_only_std_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i][PORT_SD] |-> (in_kind[2*i +: 2] == 2'b10));
    p_load_general_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready[i] && in_kind[2*i +: 2] == 2'b00) |-> (gnt[i][NGEN+1:NGEN] == 2'b00));
    p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid[i] && in_kind[2*i +: 2] == 2'b11) |-> !in_ready[i]);
    p_one_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt[i]));
    for (genvar k = i + 1; k < N_SLOT; k++) begin : g_young
      p_kind_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[i] && in_valid[k] && in_kind[2*i +: 2] != 2'b11 &&
         in_kind[2*i +: 2] == in_kind[2*k +: 2] && !in_ready[i]) |-> !in_ready[k]);
    end
  end
endmodule

bind mem_port_dispatch mpd_checker #(.N_SLOT(N_SLOT), .NGEN(NGEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_kind     (in_kind),
  .in_indexed  (in_indexed),
  .in_ready    (in_ready),
  .iss_valid   (iss_valid),
  .iss_wide    (iss_wide),
  .gen_is_load (gen_is_load),
  .gnt         (gnt)
);

// File: tb/mem_port_dispatch_tb_top.sv
`timescale 1ns/1ps
module mem_port_dispatch_tb_top;
  localparam int NS = 4;
  localparam int NG = 2;
  localparam int TW = 6;
  localparam int NP = NG + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NS-1:0]    in_valid = '0;
  logic [2*NS-1:0]  in_kind = '0;
  logic [NS-1:0]    in_indexed = '0;
  logic [NS-1:0]    in_wide = '0;
  logic [NS*TW-1:0] in_tag = '0;
  logic [NS-1:0]    in_ready;
  logic [NP-1:0]    iss_valid;
  logic [NP*TW-1:0] iss_tag;
  logic [NP-1:0]    iss_wide;
  logic [NG-1:0]    gen_is_load;

  mem_port_dispatch #(.N_SLOT(NS), .NGEN(NG), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_indexed(in_indexed), .in_wide(in_wide), .in_tag(in_tag),
    .in_ready(in_ready), .iss_valid(iss_valid), .iss_tag(iss_tag),
    .iss_wide(iss_wide), .gen_is_load(gen_is_load)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // stimulus slots
  int sv[NS], sk[NS], sx[NS], sw[NS], st[NS];
  // model state: second-half flags
  int m_g[NG];
  int m_sd;

  task automatic clear_slots();
    for (int i = 0; i < NS; i++) begin
      sv[i] = 0; sk[i] = 0; sx[i] = 0; sw[i] = 0; st[i] = 0;
    end
  endtask

  task automatic put(int i, int k, int x, int w, int t);
    sv[i] = 1; sk[i] = k; sx[i] = x; sw[i] = w; st[i] = t;
  endtask

  task automatic step(string lbl);
    logic [NS-1:0]    e_rdy;
    logic [NP-1:0]    e_vld, e_wid;
    logic [NP*TW-1:0] e_tag;
    logic [NG-1:0]    e_ld;
    int used[NP];
    int blocked[4];
    int where;
    @(negedge clk);
    for (int i = 0; i < NS; i++) begin
      in_valid[i]       = sv[i][0];
      in_kind[2*i +: 2] = sk[i][1:0];
      in_indexed[i]     = sx[i][0];
      in_wide[i]        = sw[i][0];
      in_tag[i*TW +: TW] = st[i][TW-1:0];
    end
    #1;
    e_rdy = '0; e_vld = '0; e_wid = '0; e_tag = '0; e_ld = '0;
    for (int p = 0; p < NP; p++) used[p] = 0;
    for (int k = 0; k < 4; k++) blocked[k] = 0;
    for (int i = 0; i < NS; i++) begin
      if (sv[i] == 0 || sk[i] == 3 || blocked[sk[i]] != 0) continue;
      where = -1;
      if (sk[i] == 0) begin
        for (int j = 0; j < NG; j++)
          if (where < 0 && used[j] == 0 && m_g[j] == 0) where = j;
      end else if (sk[i] == 1) begin
        if (sx[i] == 0 && used[2] == 0) where = 2;
        for (int j = 0; j < NG; j++)
          if (where < 0 && used[j] == 0 && m_g[j] != 0) where = j;
        for (int j = 0; j < NG; j++)
          if (where < 0 && used[j] == 0) where = j;
      end else begin
        if (used[3] == 0 && m_sd == 0) where = 3;
      end
      if (where < 0) blocked[sk[i]] = 1;
      else begin
        used[where] = 1;
        e_rdy[i] = 1'b1;
        e_vld[where] = 1'b1;
        e_tag[where*TW +: TW] = st[i][TW-1:0];
        e_wid[where] = (sw[i] != 0) && (sk[i] != 1);
        if (where < NG && sk[i] == 0) e_ld[where] = 1'b1;
      end
    end
    n_vec++;
    if (in_ready !== e_rdy || iss_valid !== e_vld || iss_tag !== e_tag ||
        iss_wide !== e_wid || gen_is_load !== e_ld) begin
      n_bad++;
      $display("FAIL %s: rdy=%b vld=%b tag=%h wide=%b ld=%b expected rdy=%b vld=%b tag=%h wide=%b ld=%b",
               lbl, in_ready, iss_valid, iss_tag, iss_wide, gen_is_load,
               e_rdy, e_vld, e_tag, e_wid, e_ld);
    end
    for (int j = 0; j < NG; j++) m_g[j] = (e_vld[j] && e_ld[j] && e_wid[j]) ? 1 : 0;
    m_sd = (e_vld[3] && e_wid[3]) ? 1 : 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_g[0] = 0; m_g[1] = 0; m_sd = 0;
    clear_slots();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11: idle after reset
    step("R11 reset idle");
    // R2: peak mix fully accepted (kind 0 load, 1 sta, 2 std)
    clear_slots(); put(0,0,0,0,1); put(1,0,1,0,2); put(2,1,0,0,3); put(3,2,0,0,4);
    step("R2 peak two loads + simple sta + std");
    // R1: three loads, third rejected
    clear_slots(); put(0,0,0,0,5); put(1,0,0,0,6); put(2,0,0,0,7);
    step("R1 three loads");
    // R3: indexed stas use general ports, simple goes to port 2
    clear_slots(); put(0,1,1,0,8); put(1,1,1,0,9); put(2,1,0,0,10);
    step("R3 indexed sta on general ports");
    clear_slots(); put(0,1,1,0,11); put(1,1,1,0,12); put(2,1,1,0,13);
    step("R3 third indexed sta rejected");
    // R2: simple sta overflow to general
    clear_slots(); put(0,1,0,0,14); put(1,1,0,0,15); put(2,0,0,0,16);
    step("R2 second simple sta on general port");
    // R5: older sta claims general port before loads
    clear_slots(); put(0,1,1,0,17); put(1,0,0,0,18); put(2,0,0,0,19);
    step("R5 age order");
    // R6: rejection passes on within a kind
    clear_slots(); put(0,1,1,0,20); put(1,1,1,0,21); put(2,1,1,0,22); put(3,1,0,0,23);
    step("R6 younger simple sta blocked");
    // R4: two store-data, one accepted
    clear_slots(); put(0,2,0,0,24); put(1,2,0,0,25); put(2,0,0,0,26);
    step("R4 single std per cycle");
    // R7: wide load then load + indexed sta
    clear_slots(); put(0,0,0,1,27);
    step("R7 wide load issue");
    clear_slots(); put(0,0,0,0,28); put(1,1,1,0,29);
    step("R7 second half takes sta, load elsewhere");
    clear_slots(); put(0,0,0,1,30);
    step("R7 wide load again");
    clear_slots(); put(0,0,0,0,31); put(1,0,0,0,32);
    step("R7 only one load in second half");
    // R8: wide std blocks next cycle
    clear_slots(); put(0,2,0,1,33);
    step("R8 wide std issue");
    clear_slots(); put(0,2,0,0,34);
    step("R8 std rejected in second half");
    step("R8 std accepted after second half");
    // R10: reserved kind ignored
    clear_slots(); put(0,3,0,0,35); put(1,0,0,0,36); put(2,3,1,1,37);
    step("R10 reserved kind");
    // R9: nothing valid, garbage fields
    clear_slots(); sk[0] = 1; st[0] = 40; sw[1] = 1; sk[2] = 2;
    step("R9 no valid input");
    // R5: random mix
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < NS; i++) begin
        sv[i] = ($urandom % 4) != 0;
        sk[i] = $urandom % 4;
        if (sk[i] == 3 && ($urandom % 2) == 0) sk[i] = 0;
        sx[i] = $urandom % 2;
        sw[i] = ($urandom % 3) == 0;
        st[i] = $urandom % 64;
      end
      step("R5 random mix");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule